// File: doc/BRIEF.md
# Timer Capture Burst Window

This block sits beside a timer's capture channels. It lets a DMA controller collect several consecutive timer registers from one fixed address each time a capture event fires, so the CPU does not have to read the capture registers. Software programs a burst control register with a starting word index (the base) and a transfer count. It then sets a request-enable bit for capture channel 1 or capture channel 3. On each enabled capture event the block raises a DMA request. Each acknowledge steps an internal pointer to the next word of the timer register map. After the last word of the burst the request drops and the pointer returns to the base.

The usual setup points the base at capture register 1 (or 3) with a length of two. Each period edge then yields the pair of capture snapshots for that channel pair, and two events fill four 32-bit words in memory. Clearing the enable bits and zeroing the burst control register stops all further requests. A capture event that arrives while a burst is still running is dropped and raises a sticky overrun flag.

Top module: `tmr_dma_burst`

## Requirements
- R1: A synchronous active-low reset clears the burst control register, the enable register, the DMA request and the overrun flag.
- R2: The register port decodes three byte offsets:
  - 0x48 is the burst control register. The base index is in bits [4:0], the length field in bits [12:8], and all other bits read as 0.
  - 0x0C is the 16-bit enable register, which reads back exactly as written.
  - Any other offset reads 0, except 0x4C (see R7).
- R3: A capture event on channel 1 while enable bit 9 is set, or on channel 3 while enable bit 11 is set, raises `dma_req` in the next cycle. An event whose enable bit is clear raises nothing.
- R4: `dma_data` holds the 32-bit word at index base+count, where count is the number of transfers already acknowledged in this burst. The index is the byte offset divided by four.
  - Indices 13, 14, 15 and 16 (offsets 0x34..0x40) return capture registers 1 to 4, zero-extended.
  - Index 3 returns the enable register and index 18 returns the burst control register.
  - Every other index returns 0.
- R5: Each `dma_ack` while `dma_req` is high advances the count. A burst has length field + 1 transfers, so a field value of 1 means two. After the last transfer is acknowledged, `dma_req` is low in the next cycle and the next burst starts again at the base.
- R6: An enabled capture event while `dma_req` is high starts no new burst and does not disturb the running one. It sets `overrun`, which stays set until the next write to the burst control register. If a set and a clear happen in the same cycle, the set wins.
- R7: A read of the data window at 0x4C returns the same word as `dma_data` (the base word when idle) and does not advance the count.
- R8: With the enable register written to 0 and the burst control register written to 0, capture events on either channel raise no request.
- R9: A `dma_ack` while `dma_req` is low has no effect: the next burst still starts with the word at the base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| cap_evt1 | input | 1 | Capture event pulse, channel 1 |
| cap_evt3 | input | 1 | Capture event pulse, channel 3 |
| cap_val | input | 64 | Capture registers 1..4, 16 bits each, register 1 in the low bits |
| dma_req | output | 1 | DMA request, high for the whole burst |
| dma_ack | input | 1 | DMA acknowledge, one per transfer |
| dma_data | output | 32 | Current burst word |
| overrun | output | 1 | Sticky flag: an event was dropped during a burst |

## Verification
The burst engine is tried in three groups.

- A length-two burst based at capture register 1 is run twice with different capture values. This shows that the pointer returns to the base and tells live capture values apart from stale ones.
- A length-four burst based at capture register 3 runs across an empty slot and onto the control register itself. This separates the index mapping of the capture words from the zero and readback slots, and a capture value of all ones shows the zero extension.
- Acknowledges are held off for several cycles, sent while idle, and sent in the same cycle as a fresh event. Events arrive during a burst, and the enable bits are cleared. These cases separate a correct pointer from one that runs ahead, restarts or counts spurious acknowledges.

A behavioural model in the bench predicts every output on every clock.

// File: rtl/tdb_pkg.sv
// Shared constants and types for the timer capture burst window.
// Assumes a word-addressed timer map where index = byte offset / 4.
package tdb_pkg;

    // Byte offsets the block decodes
    localparam logic [7:0] OFS_ENA  = 8'h0C;
    localparam logic [7:0] OFS_CCR1 = 8'h34;
    localparam logic [7:0] OFS_BCTL = 8'h48;
    localparam logic [7:0] OFS_WIN  = 8'h4C;

    // Word indices derived from the offsets
    localparam int IDX_ENA  = int'(OFS_ENA)  / 4;
    localparam int IDX_CCR1 = int'(OFS_CCR1) / 4;
    localparam int IDX_BCTL = int'(OFS_BCTL) / 4;

    localparam int NUM_CAP  = 4;

    // Burst control field layout
    localparam int FLD_W    = 5;
    localparam int BASE_LSB = 0;
    localparam int LEN_LSB  = 8;

    // Enable bits that arm requests for channel 1 and channel 3
    localparam int CH1_ENA_BIT = 9;
    localparam int CH3_ENA_BIT = 11;

    typedef struct packed {
        logic [FLD_W-1:0] len;
        logic [FLD_W-1:0] base;
    } bctl_t;

endpackage

// File: rtl/tdb_regfile.sv
// Holds the burst control and enable registers and decodes writes.
// Assumes single-cycle write strobes; reads are handled by the top.
module tdb_regfile
    import tdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int ENA_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output bctl_t             bctl_q,
    output logic [ENA_W-1:0]  ena_q,
    output logic              bctl_wr
);

    // Decode a write to the burst control register
    always_comb begin
        bctl_wr = wr && (addr == ADDR_W'(OFS_BCTL));
    end

    // Store control fields and the enable word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bctl_q <= '0;
            ena_q  <= '0;
        end else begin
            if (bctl_wr) begin
                bctl_q.base <= wdata[BASE_LSB +: FLD_W];
                bctl_q.len  <= wdata[LEN_LSB  +: FLD_W];
            end
            if (wr && (addr == ADDR_W'(OFS_ENA))) begin
                ena_q <= wdata[ENA_W-1:0];
            end
        end
    end

endmodule

// File: rtl/tdb_burst_seq.sv
// Burst sequencer: starts a burst on a trigger, counts acknowledged
// transfers, ends after len+1 of them and flags dropped triggers.
// Assumes trigger and ack are synchronous single-cycle qualifiers.
module tdb_burst_seq #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             ack,
    input  logic             clr_ovr,
    input  logic [CNT_W-1:0] len,
    output logic             busy,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr
);

    logic last_xfer;

    // Flag the acknowledge that completes the burst
    always_comb begin
        last_xfer = busy && ack && (cnt == len);
    end

    // Track burst activity and the transfer count
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (last_xfer) begin
                busy <= 1'b0;
                cnt  <= '0;
            end else if (ack) begin
                cnt <= cnt + 1'b1;
            end
        end else if (trig) begin
            busy <= 1'b1;
            cnt  <= '0;
        end
    end

    // Sticky overrun: set by a trigger during a burst, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovr <= 1'b0;
        end else if (busy && trig) begin
            ovr <= 1'b1;
        end else if (clr_ovr) begin
            ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/tdb_word_sel.sv
// Maps a word index of the timer register map to the 32-bit value seen
// through the burst window. Unmapped indices return zero.
// Assumes capture values arrive flattened, register 1 in the low bits.
module tdb_word_sel
    import tdb_pkg::*;
#(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32,
    parameter int CAP_W  = 16,
    parameter int ENA_W  = 16
) (
    input  logic [IDX_W-1:0]         idx,
    input  logic [NUM_CAP*CAP_W-1:0] cap_val,
    input  logic [ENA_W-1:0]         ena_q,
    input  bctl_t                    bctl_q,
    output logic [DATA_W-1:0]        word
);

    logic [NUM_CAP-1:0] hit;
    logic [DATA_W-1:0]  cap_word [NUM_CAP];
    logic [DATA_W-1:0]  bctl_word;

    // One decoder and zero-extender per capture register
    for (genvar g = 0; g < NUM_CAP; g++) begin : g_cap
        assign hit[g]      = (idx == IDX_W'(IDX_CCR1 + g));
        assign cap_word[g] = DATA_W'(cap_val[g*CAP_W +: CAP_W]);
    end

    // Readback image of the burst control register
    always_comb begin
        bctl_word = '0;
        bctl_word[BASE_LSB +: FLD_W] = bctl_q.base;
        bctl_word[LEN_LSB  +: FLD_W] = bctl_q.len;
    end

    // Select the word for the current index
    always_comb begin
        word = '0;
        if (idx == IDX_W'(IDX_ENA))  word = DATA_W'(ena_q);
        if (idx == IDX_W'(IDX_BCTL)) word = bctl_word;
        for (int i = 0; i < NUM_CAP; i++) begin
            if (hit[i]) word = cap_word[i];
        end
    end

endmodule

// File: rtl/tmr_dma_burst.sv
// Top of the timer capture burst window. Enabled capture events start a
// DMA burst that walks the register map from a programmable base.
// Assumes register reads have no side effects and DMA acks are pulses.
module tmr_dma_burst
    import tdb_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CAP_W  = 16,
    parameter int ENA_W  = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     reg_wr,
    input  logic [ADDR_W-1:0]        reg_addr,
    input  logic [DATA_W-1:0]        reg_wdata,
    output logic [DATA_W-1:0]        reg_rdata,
    input  logic                     cap_evt1,
    input  logic                     cap_evt3,
    input  logic [NUM_CAP*CAP_W-1:0] cap_val,
    output logic                     dma_req,
    input  logic                     dma_ack,
    output logic [DATA_W-1:0]        dma_data,
    output logic                     overrun
);

    localparam int IDX_W = FLD_W + 1;

    bctl_t            bctl_q;
    logic [ENA_W-1:0] ena_q;
    logic             bctl_wr;
    logic             trig;
    logic             busy;
    logic [FLD_W-1:0] cnt;
    logic [IDX_W-1:0] idx;
    logic [DATA_W-1:0] word;
    logic [DATA_W-1:0] bctl_rd;

    tdb_regfile #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ENA_W  (ENA_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (reg_wr),
        .addr    (reg_addr),
        .wdata   (reg_wdata),
        .bctl_q  (bctl_q),
        .ena_q   (ena_q),
        .bctl_wr (bctl_wr)
    );

    // Qualify capture events with their request-enable bits
    always_comb begin
        trig = (cap_evt1 && ena_q[CH1_ENA_BIT]) ||
               (cap_evt3 && ena_q[CH3_ENA_BIT]);
    end

    tdb_burst_seq #(
        .CNT_W (FLD_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig),
        .ack     (dma_ack),
        .clr_ovr (bctl_wr),
        .len     (bctl_q.len),
        .busy    (busy),
        .cnt     (cnt),
        .ovr     (overrun)
    );

    // Current word index: base plus transfers done
    always_comb begin
        idx = IDX_W'(bctl_q.base) + IDX_W'(cnt);
    end

    tdb_word_sel #(
        .IDX_W  (IDX_W),
        .DATA_W (DATA_W),
        .CAP_W  (CAP_W),
        .ENA_W  (ENA_W)
    ) u_sel (
        .idx     (idx),
        .cap_val (cap_val),
        .ena_q   (ena_q),
        .bctl_q  (bctl_q),
        .word    (word)
    );

    // Drive the DMA side
    always_comb begin
        dma_req  = busy;
        dma_data = word;
    end

    // Readback image of the control register for the bus
    always_comb begin
        bctl_rd = '0;
        bctl_rd[BASE_LSB +: FLD_W] = bctl_q.base;
        bctl_rd[LEN_LSB  +: FLD_W] = bctl_q.len;
    end

    // Register read mux, side-effect free
    always_comb begin
        unique case (reg_addr)
            ADDR_W'(OFS_ENA):  reg_rdata = DATA_W'(ena_q);
            ADDR_W'(OFS_BCTL): reg_rdata = bctl_rd;
            ADDR_W'(OFS_WIN):  reg_rdata = word;
            default:           reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/tmr_dma_burst_chk.sv
// Checker for the burst window, attached to the top by bind.
// Observes ports plus the enable and control-write signals.
module tmr_dma_burst_chk
    import tdb_pkg::*;
#(
    parameter int ENA_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cap_evt1,
    input logic             cap_evt3,
    input logic [ENA_W-1:0] ena_q,
    input logic             bctl_wr,
    input logic             dma_req,
    input logic             dma_ack,
    input logic             overrun
);

    logic armed_evt;

    // Enabled event seen at the ports
    always_comb begin
        armed_evt = (cap_evt1 && ena_q[CH1_ENA_BIT]) ||
                    (cap_evt3 && ena_q[CH3_ENA_BIT]);
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!dma_req && !overrun));

    // R3
    start_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && armed_evt) |=> dma_req);

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !dma_ack) |=> dma_req);

    // R6
    ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && armed_evt) |=> overrun);

    // R6
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (overrun && !bctl_wr) |=> overrun);

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dma_req && !armed_evt) |=> !dma_req);

endmodule

bind tmr_dma_burst tmr_dma_burst_chk #(.ENA_W(ENA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cap_evt1 (cap_evt1),
    .cap_evt3 (cap_evt3),
    .ena_q    (ena_q),
    .bctl_wr  (bctl_wr),
    .dma_req  (dma_req),
    .dma_ack  (dma_ack),
    .overrun  (overrun)
);

// File: tb/tmr_dma_burst_bench.sv
`timescale 1ns/1ps
module tmr_dma_burst_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = 8'h00;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        cap_evt1 = 1'b0;
    logic        cap_evt3 = 1'b0;
    logic [63:0] cap_val = '0;
    logic        dma_req;
    logic        dma_ack = 1'b0;
    logic [31:0] dma_data;
    logic        overrun;

    int n_chk = 0;
    int n_bad = 0;
    bit cmp_on = 1'b0;

    // Reference model state
    int m_busy, m_cnt, m_base, m_len, m_en, m_ovr;

    always #2.5 clk = ~clk;

    tmr_dma_burst u_tmr_dma_burst (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_evt1(cap_evt1),
        .cap_evt3(cap_evt3), .cap_val(cap_val), .dma_req(dma_req),
        .dma_ack(dma_ack), .dma_data(dma_data), .overrun(overrun)
    );

    task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    function automatic logic [31:0] m_ctrl();
        return 32'((m_len << 8) | m_base);
    endfunction

    function automatic logic [31:0] m_word(int idx);
        case (idx)
            3:  return 32'(m_en);
            13: return {16'h0, cap_val[15:0]};
            14: return {16'h0, cap_val[31:16]};
            15: return {16'h0, cap_val[47:32]};
            16: return {16'h0, cap_val[63:48]};
            18: return m_ctrl();
            default: return 32'h0;
        endcase
    endfunction

    // Reference model update at each clock edge
    always @(posedge clk) begin
        int trig, nxt_ovr;
        if (!rst_n) begin
            m_busy = 0; m_cnt = 0; m_base = 0; m_len = 0; m_en = 0; m_ovr = 0;
        end else begin
            trig = (cap_evt1 && m_en[9]) || (cap_evt3 && m_en[11]);
            nxt_ovr = (reg_wr && reg_addr == 8'h48) ? 0 : m_ovr;
            if (m_busy != 0) begin
                if (trig != 0) nxt_ovr = 1;
                if (dma_ack) begin
                    if (m_cnt == m_len) begin m_busy = 0; m_cnt = 0; end
                    else m_cnt = m_cnt + 1;
                end
            end else if (trig != 0) begin
                m_busy = 1; m_cnt = 0;
            end
            m_ovr = nxt_ovr;
            if (reg_wr && reg_addr == 8'h48) begin
                m_base = int'(reg_wdata[4:0]);
                m_len  = int'(reg_wdata[12:8]);
            end
            if (reg_wr && reg_addr == 8'h0C) m_en = int'(reg_wdata[15:0]);
        end
    end

    // Compare every output against the model mid-cycle
    always @(negedge clk) begin
        logic [31:0] exp_rd;
        if (cmp_on) begin
            check("R3/R5 dma_req", 32'(dma_req), 32'(m_busy));
            check("R4 dma_data", dma_data, m_word(m_base + m_cnt));
            check("R6 overrun", 32'(overrun), 32'(m_ovr));
            case (reg_addr)
                8'h0C:   exp_rd = 32'(m_en);
                8'h48:   exp_rd = m_ctrl();
                8'h4C:   exp_rd = m_word(m_base + m_cnt);
                default: exp_rd = 32'h0;
            endcase
            check("R2/R7 reg_rdata", reg_rdata, exp_rd);
        end
    end

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic mid();
        @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic ev1();
        cap_evt1 = 1'b1; tick(); cap_evt1 = 1'b0;
    endtask

    task automatic ev3();
        cap_evt3 = 1'b1; tick(); cap_evt3 = 1'b0;
    endtask

    task automatic ack();
        dma_ack = 1'b1; tick(); dma_ack = 1'b0;
    endtask

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        cap_val = {16'h4444, 16'h3333, 16'h2222, 16'h1111};
        repeat (3) tick();
        rst_n = 1'b1;
        mid();
        check("R1 req after reset", 32'(dma_req), 32'h0);
        check("R1 overrun after reset", 32'(overrun), 32'h0);
        reg_addr = 8'h48; mid();
        check("R1 ctrl after reset", reg_rdata, 32'h0);
        cmp_on = 1'b1;
        tick();

        // R2: field masking and readback
        wr(8'h48, 32'hFFFF_E1ED);
        reg_addr = 8'h48; mid();
        check("R2 ctrl readback", reg_rdata, 32'h0000_010D);
        tick();
        wr(8'h0C, 32'h0000_0200);
        reg_addr = 8'h0C; mid();
        check("R2 enable readback", reg_rdata, 32'h0000_0200);
        tick();

        // R7: idle window shows the base word
        reg_addr = 8'h4C; mid();
        check("R7 idle window", reg_rdata, 32'h0000_1111);
        tick();

        // R3/R4/R5: two-word burst on channel 1
        ev1(); mid();
        check("R3 req on ch1 event", 32'(dma_req), 32'h1);
        check("R4 first word", dma_data, 32'h0000_1111);
        tick(); tick(); mid();
        check("R7 no advance without ack", reg_rdata, 32'h0000_1111);
        ack(); mid();
        check("R5 second word", dma_data, 32'h0000_2222);
        ack(); mid();
        check("R5 req drops after last", 32'(dma_req), 32'h0);

        // R5: next burst restarts at base with fresh values
        cap_val = {16'hDDDD, 16'hCCCC, 16'hBBBB, 16'hAAAA};
        ev1(); mid();
        check("R5 restart at base", dma_data, 32'h0000_AAAA);
        ack(); ack();

        // R3: channel 3 without its enable bit
        ev3(); mid();
        check("R3 ch3 disabled no req", 32'(dma_req), 32'h0);

        // R4: four-word burst from capture 3 with zero extension
        cap_val = {16'h4444, 16'hFFFF, 16'h2222, 16'h1111};
        wr(8'h0C, 32'h0000_0A00);
        wr(8'h48, 32'h0000_030F);
        ev3(); mid();
        check("R4 cap3 zero-extended", dma_data, 32'h0000_FFFF);
        ack(); mid();
        check("R4 cap4", dma_data, 32'h0000_4444);
        // R6: event during burst
        ev1(); mid();
        check("R6 overrun set", 32'(overrun), 32'h1);
        check("R6 burst undisturbed", dma_data, 32'h0000_4444);
        ack(); mid();
        check("R4 empty slot", dma_data, 32'h0);
        ack(); mid();
        check("R4 ctrl slot", dma_data, 32'h0000_030F);
        ack(); mid();
        check("R6 overrun sticky", 32'(overrun), 32'h1);
        check("R5 req low after four", 32'(dma_req), 32'h0);
        wr(8'h48, 32'h0000_010D); mid();
        check("R6 overrun cleared by ctrl write", 32'(overrun), 32'h0);
        tick();

        // R9: stray ack while idle
        ack(); ack();
        ev1(); mid();
        check("R9 stray ack ignored", dma_data, 32'h0000_1111);
        ack();
        // R6: event together with the last ack
        dma_ack = 1'b1; cap_evt1 = 1'b1; tick();
        dma_ack = 1'b0; cap_evt1 = 1'b0; mid();
        check("R6 event on last ack no burst", 32'(dma_req), 32'h0);
        check("R6 event on last ack overrun", 32'(overrun), 32'h1);
        tick();

        // R8: stop everything
        wr(8'h0C, 32'h0);
        wr(8'h48, 32'h0);
        ev1(); ev3(); mid();
        check("R8 no req after stop", 32'(dma_req), 32'h0);
        tick(); tick();

        cmp_on = 1'b0;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule